// File: doc/BRIEF.md
# Receive Descriptor Ring Status Tracker

This block keeps the bookkeeping for one circular receive descriptor ring that belongs to a single CPU port of a packet queue engine. Software sets a ring base address and an entry count through a small register write port. A producer strobe marks that one more descriptor has been filled, which moves the write index forward. The consumer hands a descriptor back by writing its address to the finish register, which moves the read index forward by one entry.

Both indices carry a wrap flag, so a full ring and an empty ring can be told apart without giving up an entry. The block presents a packed pointer word and a status word. The status word holds the number of filled entries and flags for empty and full. It also presents the address of the next descriptor the consumer should handle, a readback of the control register, and a level interrupt that is gated by the number of filled entries. The descriptor memory and the bus fabric are outside the block.

Top module: `rxring_tracker`

## Requirements
- R1: `ptr_stat_o` packs the write index in bits [14:0], the write wrap flag in bit 15, the read index in bits [30:16] and the read wrap flag in bit 31.
- R2: `ring_stat_o` carries the filled-entry count in bits [15:0], the empty flag in bit 30 and the full flag in bit 31, and bits [29:16] are zero.
- R3: With an entry count N (1 to 32768), an index that advances from N-1 goes to 0 and its wrap flag toggles; from any other value it goes up by one.
- R4: The ring is empty when the two indices and the two wrap flags are equal. It is full when the indices are equal and the wrap flags differ. The count is write minus read when the flags match, and N minus read plus write when they differ.
- R5: A register write to address 3 (finish) retires one entry on the next clock edge. A finish write while the ring is empty leaves the read index and flag unchanged.
- R6: A producer strobe while the ring is full does not move the write index. It sets a sticky overflow flag, read in control bit 31, which only reset or soft reset clears.
- R7: A write to address 2 (control) sets soft reset from bit 0, interrupt enable from bit 1, threshold enable from bit 2 and the threshold from bits [18:3]. When the threshold written is zero, threshold enable is stored as 0. Control readback keeps these positions, and bits [30:19] read as zero.
- R8: While soft reset is stored as 1, each clock edge puts both indices, both wrap flags and the overflow flag at zero, and producer strobes and finish writes are ignored.
- R9: `cur_ptr_o` equals the base address (register address 0) plus the read index times 16.
- R10: `irq_o` is high only when interrupt enable is set and either threshold enable is clear and the ring is not empty, or threshold enable is set and the count is at least the threshold.
- R11: After the synchronous reset, base, control, indices and flags are zero and the entry count (register address 1, bits [15:0]) is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_push | input | 1 | Producer has filled one descriptor |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 size, 2 control, 3 finish |
| reg_wdata | input | 32 | Register write data |
| base_o | output | 32 | Ring base address readback |
| size_o | output | 16 | Ring entry count readback |
| ctrl_o | output | 32 | Control readback with the overflow flag in bit 31 |
| ptr_stat_o | output | 32 | Packed indices and wrap flags |
| ring_stat_o | output | 32 | Filled count, empty and full flags |
| cur_ptr_o | output | 32 | Address of the next descriptor to consume |
| irq_o | output | 1 | Ring interrupt |

## Verification
The assertions assume that the entry count changes only while soft reset is held or the ring is idle and empty. They also assume that it stays between 1 and 32768, since a count changed under live indices can leave an index above the new limit. The stimulus follows this by writing the size, pulsing soft reset before it moves any entry, and using only small counts. Producer strobes and finish writes are otherwise unconstrained. They are driven on the same cycles, against a full ring, against an empty ring and while soft reset is held.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive ring tracker.
// Assumes a 32-bit register data path; control field positions are fixed here.
package rxr_pkg;
    localparam int DATA_W = 32;

    // Register select codes on the write port.
    typedef enum logic [1:0] {
        RA_BASE   = 2'd0,
        RA_SIZE   = 2'd1,
        RA_CTRL   = 2'd2,
        RA_FINISH = 2'd3
    } rxr_addr_e;

    // Control word bit positions.
    localparam int CB_SRST  = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_THREN = 2;
    localparam int CB_THR   = 3;
    localparam int CB_OVF   = 31;
endpackage

// File: rtl/rxr_regs.sv
// Software-visible configuration for the ring: base, entry count, control.
// Decodes the finish address into a one-cycle retire strobe.
// Assumes one write per cycle; the threshold field is CNT_W bits wide.
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int DEF_SIZE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  size,
    output logic              srst,
    output logic              irq_en,
    output logic              thr_en,
    output logic [CNT_W-1:0]  thr,
    output logic              finish_stb,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int THR_HI = CB_THR + CNT_W - 1;

    logic [CNT_W-1:0] thr_in;
    assign thr_in = wdata[THR_HI:CB_THR];

    // Base address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (we && addr == RA_BASE)
            base <= wdata[ADDR_W-1:0];
    end

    // Ring entry count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            size <= CNT_W'(DEF_SIZE);
        else if (we && addr == RA_SIZE)
            size <= wdata[CNT_W-1:0];
    end

    // Control fields; a zero threshold forces the threshold enable off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst   <= 1'b0;
            irq_en <= 1'b0;
            thr_en <= 1'b0;
            thr    <= '0;
        end else if (we && addr == RA_CTRL) begin
            srst   <= wdata[CB_SRST];
            irq_en <= wdata[CB_IRQEN];
            thr_en <= wdata[CB_THREN] && (thr_in != '0);
            thr    <= thr_in;
        end
    end

    // Finish writes become a retire strobe in the same cycle.
    assign finish_stb = we && (addr == RA_FINISH);

    // Control readback assembly.
    always_comb begin
        ctrl_word                 = '0;
        ctrl_word[CB_SRST]        = srst;
        ctrl_word[CB_IRQEN]       = irq_en;
        ctrl_word[CB_THREN]       = thr_en;
        ctrl_word[THR_HI:CB_THR]  = thr;
        ctrl_word[CB_OVF]         = ovf;
    end

    // R7: a stored threshold enable never goes with a zero threshold.
    a_r7_thr_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(thr_en && thr == '0));
    // R7: a control write with a zero threshold leaves the enable clear.
    a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_CTRL && thr_in == '0) |=> !thr_en);
endmodule

// File: rtl/rxr_index.sv
// One ring index with its wrap flag.
// Advances by one per strobe, returns to zero after size-1 and toggles the flag.
// Assumes size is 1..2**IDX_W and is not changed while the index is live.
module rxr_index #(
    parameter int CNT_W = 16,
    parameter int IDX_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] size,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);
    localparam int PAD = CNT_W - IDX_W;

    logic [CNT_W-1:0] last;
    logic             at_last;

    assign last    = size - CNT_W'(1);
    assign at_last = ({{PAD{1'b0}}, idx} == last);

    // Index and wrap flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx  <= '0;
            wrap <= 1'b0;
        end else if (adv) begin
            if (at_last) begin
                idx  <= '0;
                wrap <= ~wrap;
            end else begin
                idx  <= idx + IDX_W'(1);
            end
        end
    end

    // R3: stepping off the last slot returns to zero with the flag toggled.
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && at_last) |=> (idx == '0 && wrap != $past(wrap)));
    // R3: an ordinary step moves up by one and keeps the flag.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !at_last) |=> (idx == $past(idx) + IDX_W'(1) && $stable(wrap)));
endmodule

// File: rtl/rxr_occupancy.sv
// Derives fill level, empty/full flags and the interrupt from the two indices.
// Pure combinational; assumes both indices are below the entry count.
module rxr_occupancy #(
    parameter int CNT_W = 16,
    parameter int IDX_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] size,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_wrap,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_wrap,
    input  logic             irq_en,
    input  logic             thr_en,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] avail,
    output logic             empty,
    output logic             full,
    output logic             irq
);
    localparam int PAD = CNT_W - IDX_W;

    logic [CNT_W-1:0] wr_ext, rd_ext;
    logic             same_idx, same_wrap;

    assign wr_ext    = {{PAD{1'b0}}, wr_idx};
    assign rd_ext    = {{PAD{1'b0}}, rd_idx};
    assign same_idx  = (wr_idx == rd_idx);
    assign same_wrap = (wr_wrap == rd_wrap);

    // Fill level and boundary flags.
    always_comb begin
        empty = same_idx && same_wrap;
        full  = same_idx && !same_wrap;
        if (same_wrap)
            avail = wr_ext - rd_ext;
        else
            avail = size - rd_ext + wr_ext;
    end

    // Interrupt condition: plain non-empty or threshold-gated.
    always_comb begin
        if (!irq_en)
            irq = 1'b0;
        else if (thr_en)
            irq = (avail >= thr);
        else
            irq = !empty;
    end

    // R4: the ring is never both empty and full.
    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    // R4: a full ring reports the whole entry count.
    a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (avail == size));
    // R10: the interrupt needs the enable.
    a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: rtl/rxring_tracker.sv
// Receive descriptor ring tracker for one CPU port.
// Holds base, size and control registers, the write and read indices,
// a sticky overflow flag, and drives the status words, next-descriptor
// address and interrupt. Push and finish are judged on the state before
// the edge, so a push into a full ring is dropped even if a finish lands
// in the same cycle.
module rxring_tracker
    import rxr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DEF_SIZE   = 16,
    parameter int DESC_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_push,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       base_o,
    output logic [15:0]       size_o,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       ptr_stat_o,
    output logic [31:0]       ring_stat_o,
    output logic [31:0]       cur_ptr_o,
    output logic              irq_o
);
    localparam int IDX_W  = CNT_W - 1;
    localparam int ZPAD_W = DATA_W - 2 - CNT_W;

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  size, thr, avail;
    logic              srst, irq_en, thr_en, finish_stb;
    logic [DATA_W-1:0] ctrl_word;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              wr_wrap, rd_wrap;
    logic              empty, full, irq;
    logic              ovf;
    logic              push_ok, pop_ok;

    rxr_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .DEF_SIZE (DEF_SIZE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ovf        (ovf),
        .base       (base),
        .size       (size),
        .srst       (srst),
        .irq_en     (irq_en),
        .thr_en     (thr_en),
        .thr        (thr),
        .finish_stb (finish_stb),
        .ctrl_word  (ctrl_word)
    );

    // Accept a push or a retire only when the ring is live and has room/content.
    assign push_ok = prod_push && !full && !srst;
    assign pop_ok  = finish_stb && !empty && !srst;

    rxr_index #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .adv   (push_ok),
        .size  (size),
        .idx   (wr_idx),
        .wrap  (wr_wrap)
    );

    rxr_index #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .adv   (pop_ok),
        .size  (size),
        .idx   (rd_idx),
        .wrap  (rd_wrap)
    );

    rxr_occupancy #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (size),
        .wr_idx  (wr_idx),
        .wr_wrap (wr_wrap),
        .rd_idx  (rd_idx),
        .rd_wrap (rd_wrap),
        .irq_en  (irq_en),
        .thr_en  (thr_en),
        .thr     (thr),
        .avail   (avail),
        .empty   (empty),
        .full    (full),
        .irq     (irq)
    );

    // Sticky overflow: set by a push into a full ring, cleared by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)
            ovf <= 1'b0;
        else if (prod_push && full)
            ovf <= 1'b1;
    end

    // Output packing.
    assign base_o      = base;
    assign size_o      = size;
    assign ctrl_o      = ctrl_word;
    assign ptr_stat_o  = {rd_wrap, rd_idx, wr_wrap, wr_idx};
    assign ring_stat_o = {full, empty, {ZPAD_W{1'b0}}, avail};
    assign cur_ptr_o   = base + (ADDR_W'(rd_idx) << DESC_SHIFT);
    assign irq_o       = irq;

    // R6: a push into a full ring leaves the write side still and raises overflow.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && prod_push && !srst) |=> (ovf && $stable(wr_idx) && $stable(wr_wrap)));
    // R6: overflow stays set until a reset.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !srst) |=> ovf);
    // R5: a finish against an empty ring moves nothing.
    a_r5_empty_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && finish_stb && !srst) |=> ($stable(rd_idx) && $stable(rd_wrap)));
    // R8: soft reset clears the ring state at the next edge.
    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (wr_idx == '0 && rd_idx == '0 && !wr_wrap && !rd_wrap && !ovf));
endmodule

// File: tb/sim_rxring_tracker.sv
// Bench: behavioural ring model, compared on every clock at the falling edge.
module sim_rxring_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_push = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] base_o, ctrl_o, ptr_stat_o, ring_stat_o, cur_ptr_o;
    logic [15:0] size_o;
    logic        irq_o;

    rxring_tracker u0 (
        .clk(clk), .rst_n(rst_n), .prod_push(prod_push), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .base_o(base_o),
        .size_o(size_o), .ctrl_o(ctrl_o), .ptr_stat_o(ptr_stat_o),
        .ring_stat_o(ring_stat_o), .cur_ptr_o(cur_ptr_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit started = 0;

    // Reference model state.
    int m_base, m_size, m_wi, m_ww, m_ri, m_rw, m_ovf, m_srst, m_irqen, m_then, m_thr;

    function automatic int m_avail();
        if (m_ww == m_rw) return m_wi - m_ri;
        return m_size - m_ri + m_wi;
    endfunction
    function automatic bit m_empty(); return m_wi == m_ri && m_ww == m_rw; endfunction
    function automatic bit m_full();  return m_wi == m_ri && m_ww != m_rw; endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_base = 0; m_size = 16; m_wi = 0; m_ww = 0; m_ri = 0; m_rw = 0;
            m_ovf = 0; m_srst = 0; m_irqen = 0; m_then = 0; m_thr = 0;
        end else begin
            if (m_srst != 0) begin
                m_wi = 0; m_ww = 0; m_ri = 0; m_rw = 0; m_ovf = 0;
            end else begin
                bit f, e;
                f = m_full(); e = m_empty();
                if (prod_push) begin
                    if (f) m_ovf = 1;
                    else if (m_wi == m_size - 1) begin m_wi = 0; m_ww ^= 1; end
                    else m_wi++;
                end
                if (reg_we && reg_addr == 2'd3 && !e) begin
                    if (m_ri == m_size - 1) begin m_ri = 0; m_rw ^= 1; end
                    else m_ri++;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_base = int'(reg_wdata);
                    2'd1: m_size = int'(reg_wdata[15:0]);
                    2'd2: begin
                        m_srst  = reg_wdata[0];
                        m_irqen = reg_wdata[1];
                        m_thr   = int'(reg_wdata[18:3]);
                        m_then  = (reg_wdata[2] && m_thr != 0) ? 1 : 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            logic [31:0] e_ptr, e_stat, e_ctrl, e_cur;
            bit e_irq;
            e_ptr  = {m_rw[0], m_ri[14:0], m_ww[0], m_wi[14:0]};
            e_stat = {m_full(), m_empty(), 14'd0, 16'(m_avail())};
            e_ctrl = {m_ovf[0], 12'd0, m_thr[15:0], m_then[0], m_irqen[0], m_srst[0]};
            e_cur  = 32'(m_base) + 32'(m_ri * 16);
            e_irq  = m_irqen != 0 && (m_then != 0 ? (m_avail() >= m_thr) : !m_empty());
            chk("R1/R3 pointer word", ptr_stat_o, e_ptr);
            chk("R2/R4 status word", ring_stat_o, e_stat);
            chk("R7/R6 control readback", ctrl_o, e_ctrl);
            chk("R9 current pointer", cur_ptr_o, e_cur);
            chk("R10 interrupt", {31'd0, irq_o}, {31'd0, e_irq});
            chk("R11 size/base readback", {size_o, 16'd0}, {16'(m_size), 16'd0});
            chk("R11 base readback", base_o, 32'(m_base));
        end
    end

    // One stimulus cycle, driven just after the falling edge.
    task automatic step(bit push, bit we, logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        prod_push = push; reg_we = we; reg_addr = a; reg_wdata = d;
    endtask
    task automatic idle(); step(0, 0, 2'd0, 32'd0); endtask
    task automatic wr(logic [1:0] a, logic [31:0] d); step(0, 1, a, d); endtask
    task automatic push(); step(1, 0, 2'd0, 32'd0); endtask
    task automatic fin();  step(0, 1, 2'd3, 32'hdead_0000); endtask
    function automatic logic [31:0] ctl(bit sr, bit ie, bit te, int th);
        return {13'd0, 16'(th), te, ie, sr};
    endfunction

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        idle();
        // R11: reset state.
        chk("R11 reset control", ctrl_o, 32'd0);
        chk("R11 reset status", ring_stat_o, 32'h4000_0000);
        chk("R11 reset size", {16'd0, size_o}, 32'd16);

        // Size 4, base, soft reset pulse, then live.
        wr(2'd1, 32'd4);
        wr(2'd0, 32'h1000_0000);
        wr(2'd2, ctl(1, 0, 0, 0));
        wr(2'd2, ctl(0, 0, 0, 0));
        repeat (4) push();
        idle();
        chk("R4 full after four pushes", ring_stat_o, 32'h8000_0004);
        chk("R3 write index wrapped with flag", ptr_stat_o, 32'h0000_8000);
        push();
        idle();
        chk("R6 overflow set", {31'd0, ctrl_o[31]}, 32'd1);
        chk("R6 write side held", ptr_stat_o, 32'h0000_8000);
        fin(); fin();
        idle();
        chk("R9 current pointer after two retires", cur_ptr_o, 32'h1000_0020);
        repeat (3) fin();
        idle();
        chk("R5 finish on empty ignored", ptr_stat_o, 32'h8000_8000);
        chk("R6 overflow still sticky", {31'd0, ctrl_o[31]}, 32'd1);

        // Soft reset held while pushing and finishing.
        wr(2'd2, ctl(1, 0, 0, 0));
        push(); push(); fin();
        idle();
        chk("R8 ring held at zero", ptr_stat_o, 32'd0);
        chk("R8 overflow cleared", {31'd0, ctrl_o[31]}, 32'd0);

        // Interrupt modes, size 6.
        wr(2'd1, 32'd6);
        wr(2'd2, ctl(0, 1, 0, 0));
        idle();
        chk("R10 no irq when empty", {31'd0, irq_o}, 32'd0);
        push(); idle();
        chk("R10 irq when not empty", {31'd0, irq_o}, 32'd1);
        wr(2'd2, ctl(0, 1, 1, 3));
        idle();
        chk("R10 irq below threshold", {31'd0, irq_o}, 32'd0);
        push(); push(); idle();
        chk("R10 irq at threshold", {31'd0, irq_o}, 32'd1);
        wr(2'd2, ctl(0, 1, 1, 0));
        idle();
        chk("R7 zero threshold clears enable", {29'd0, ctrl_o[2:0]}, 32'd2);

        // Mixed traffic with a small ring: pushes and finishes together.
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h0000_4000);
        wr(2'd2, ctl(1, 1, 1, 2));
        wr(2'd2, ctl(0, 1, 1, 2));
        begin
            logic [7:0] lf = 8'h5a;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                step(lf[0], lf[1] & lf[2] | (i > 300 && lf[3]), 2'd3, 32'd0);
            end
        end
        idle(); idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule